// File: doc/BRIEF.md
# Chained Byte Obfuscation Cipher

This block scrambles or unscrambles a byte stream on a command channel. It takes one byte per clock. In encode direction it turns outgoing plain bytes into obfuscated bytes. In decode direction it turns received obfuscated bytes back into plain bytes. Each byte passes through a fixed chain of XOR steps and modular add/subtract steps. Two chaining registers feed into that chain: one holds the previous plain byte and the other holds the previous obfuscated byte. As a result, the value a byte maps to depends on every byte sent before it in the same message.

Each direction keeps its own pair of chaining registers. A start-of-message pulse puts both pairs back to their fixed initial values. The pulse may arrive together with the first byte of the new message, and that byte is then transformed with the initial values. A message holds at most a parameterised number of bytes. Once that many bytes have been accepted, the input stalls until the next start-of-message pulse.

Top module: `byte_chain_cipher`

## Requirements
- R1: After reset, out_valid_o is low and in_ready_o is high.
- R2: Encode (mode_i = 0) computes u = (((p ^ s2 ^ 0x2B) - 0x05) ^ 0x35) - 0x39, then c = (((u ^ s1 ^ 0x5A) - 0xB0) ^ 0x38) - 0x45, modulo 256. At message start s1 = 0x9B and s2 = 0x54, so a first plain byte of 0x00 encodes to 0xDA.
- R3: After each encoded byte, the encode s1 takes the plain input byte and the encode s2 takes the produced byte.
- R4: Decode (mode_i = 1) computes u = (((c + 0x45) ^ 0x38) + 0xB0) ^ 0x5A ^ s1, then p = (((u + 0x39) ^ 0x35) + 0x05) ^ 0x2B ^ s2. Afterwards the decode s1 takes p and the decode s2 takes c. A first obfuscated byte of 0xDA decodes to 0x00.
- R5: sop_i restores both directions' registers to 0x9B and 0x54, including in the middle of a message. A byte accepted in the same cycle as sop_i uses the initial values.
- R6: After MAX_LEN (default 64) bytes have been accepted since the last sop_i, in_ready_o is low unless sop_i is high. A valid byte offered while in_ready_o is low is ignored and produces no output.
- R7: Decoding the encoded form of any message of 1 to MAX_LEN bytes returns the original bytes exactly.
- R8: Bytes in one direction do not change the other direction's chaining registers. Encode and decode bytes may be interleaved within a message.
- R9: Each accepted byte (in_valid_i and in_ready_o both high) produces exactly one output, with out_valid_o high in the following cycle. Cycles with no accepted byte produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sop_i | input | 1 | Start-of-message pulse |
| mode_i | input | 1 | Direction of the current byte: 0 encode, 1 decode |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Block can accept a byte this cycle |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Transformed byte |

## Verification
The hardest state to reach from the ports is a message filled to its length limit. This needs exactly MAX_LEN accepted bytes with no sop_i, after which a further byte must be offered and shown to produce nothing. The bench fills a full 64-byte message and then offers an extra byte before reopening the channel with sop_i. It also places a start-of-message pulse in the middle of a message and interleaves encode and decode bytes inside one message, so that the chaining registers of both directions are exercised in states a simple one-direction stream never produces.

// File: rtl/scr_pkg.sv
package scr_pkg;
   typedef logic [7:0] byte_t;

   localparam logic DIR_ENC = 1'b0;
   localparam logic DIR_DEC = 1'b1;

   localparam byte_t K_X0 = 8'h2B;
   localparam byte_t K_S0 = 8'h05;
   localparam byte_t K_X1 = 8'h35;
   localparam byte_t K_S1 = 8'h39;
   localparam byte_t K_X2 = 8'h5A;
   localparam byte_t K_S2 = 8'hB0;
   localparam byte_t K_X3 = 8'h38;
   localparam byte_t K_S3 = 8'h45;

   localparam byte_t SEED_PLAIN  = 8'h9B;
   localparam byte_t SEED_CIPHER = 8'h54;
endpackage

// File: rtl/scr_enc_stage.sv
module scr_enc_stage
   import scr_pkg::*;
(
   input  byte_t plain_i,
   input  byte_t s1_i,
   input  byte_t s2_i,
   output byte_t cipher_o
);
   byte_t m0, m1, m2, m3;

   always_comb begin
      m0       = plain_i ^ s2_i ^ K_X0;
      m1       = byte_t'(m0 - K_S0) ^ K_X1;
      m2       = byte_t'(m1 - K_S1) ^ s1_i ^ K_X2;
      m3       = byte_t'(m2 - K_S2) ^ K_X3;
      cipher_o = byte_t'(m3 - K_S3);
   end
endmodule

// File: rtl/scr_dec_stage.sv
module scr_dec_stage
   import scr_pkg::*;
(
   input  byte_t cipher_i,
   input  byte_t s1_i,
   input  byte_t s2_i,
   output byte_t plain_o
);
   byte_t n0, n1, n2;

   always_comb begin
      n0      = byte_t'(cipher_i + K_S3) ^ K_X3;
      n1      = byte_t'(n0 + K_S2) ^ K_X2 ^ s1_i;
      n2      = byte_t'(n1 + K_S1) ^ K_X1;
      plain_o = byte_t'(n2 + K_S0) ^ K_X0 ^ s2_i;
   end
endmodule

// File: rtl/scr_chain_state.sv
module scr_chain_state
   import scr_pkg::*;
#(
   parameter byte_t INIT_A = SEED_PLAIN,
   parameter byte_t INIT_B = SEED_CIPHER
)(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  clear_i,
   input  logic  adv_i,
   input  byte_t nxt_a_i,
   input  byte_t nxt_b_i,
   output byte_t cur_a_o,
   output byte_t cur_b_o
);
   byte_t a_q, b_q;

   // A byte arriving with the clear pulse sees the seed values.
   assign cur_a_o = clear_i ? INIT_A : a_q;
   assign cur_b_o = clear_i ? INIT_B : b_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         a_q <= INIT_A;
         b_q <= INIT_B;
      end else if (adv_i) begin
         a_q <= nxt_a_i;
         b_q <= nxt_b_i;
      end else if (clear_i) begin
         a_q <= INIT_A;
         b_q <= INIT_B;
      end
   end

   // R5: a clear with no byte leaves the seeds in place
   p_clear_seeds_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clear_i && !adv_i) |=> (a_q == INIT_A && b_q == INIT_B));

   // R8: with no byte for this direction and no clear the chain holds
   p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clear_i && !adv_i) |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/scr_len_gate.sv
module scr_len_gate #(
   parameter int MAX_LEN = 64
)(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sop_i,
   input  logic valid_i,
   output logic ready_o,
   output logic accept_o
);
   localparam int CW = $clog2(MAX_LEN + 1);
   localparam logic [CW-1:0] LIMIT = CW'(MAX_LEN);

   logic [CW-1:0] cnt_q;

   assign ready_o  = sop_i || (cnt_q < LIMIT);
   assign accept_o = valid_i && ready_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (sop_i)    cnt_q <= accept_o ? CW'(1) : '0;
      else if (accept_o) cnt_q <= cnt_q + CW'(1);
   end

   // R6: the per-message byte count never passes the limit
   p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LIMIT);
endmodule

// File: rtl/byte_chain_cipher.sv
module byte_chain_cipher
   import scr_pkg::*;
#(
   parameter int    MAX_LEN = 64,
   parameter byte_t INIT_S1 = SEED_PLAIN,
   parameter byte_t INIT_S2 = SEED_CIPHER
)(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       sop_i,
   input  logic       mode_i,
   input  logic       in_valid_i,
   input  logic [7:0] in_data_i,
   output logic       in_ready_o,
   output logic       out_valid_o,
   output logic [7:0] out_data_o
);
   localparam int NDIR = 2;

   if (MAX_LEN < 1 || MAX_LEN > 255) begin : g_bad_len
      $error("byte_chain_cipher: MAX_LEN must lie in 1..255");
   end

   logic  accept;
   logic  [NDIR-1:0] adv;
   byte_t cur_a [NDIR];
   byte_t cur_b [NDIR];
   byte_t nxt_a [NDIR];
   byte_t nxt_b [NDIR];
   byte_t res   [NDIR];
   byte_t out_q;
   logic  vld_q;

   scr_len_gate #(.MAX_LEN(MAX_LEN)) u_gate (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sop_i    (sop_i),
      .valid_i  (in_valid_i),
      .ready_o  (in_ready_o),
      .accept_o (accept)
   );

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      assign adv[d] = accept && (mode_i == logic'(d));

      scr_chain_state #(.INIT_A(INIT_S1), .INIT_B(INIT_S2)) u_state (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .clear_i (sop_i),
         .adv_i   (adv[d]),
         .nxt_a_i (nxt_a[d]),
         .nxt_b_i (nxt_b[d]),
         .cur_a_o (cur_a[d]),
         .cur_b_o (cur_b[d])
      );

      if (d == 0) begin : g_enc
         scr_enc_stage u_enc (
            .plain_i  (in_data_i),
            .s1_i     (cur_a[d]),
            .s2_i     (cur_b[d]),
            .cipher_o (res[d])
         );
         assign nxt_a[d] = in_data_i;
         assign nxt_b[d] = res[d];
      end else begin : g_dec
         scr_dec_stage u_dec (
            .cipher_i (in_data_i),
            .s1_i     (cur_a[d]),
            .s2_i     (cur_b[d]),
            .plain_o  (res[d])
         );
         assign nxt_a[d] = res[d];
         assign nxt_b[d] = in_data_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_q <= 1'b0;
         out_q <= '0;
      end else begin
         vld_q <= accept;
         if (accept) out_q <= (mode_i == DIR_DEC) ? res[1] : res[0];
      end
   end

   assign out_valid_o = vld_q;
   assign out_data_o  = out_q;

   // R9: one output exactly one cycle after each accepted byte
   p_one_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      accept |=> out_valid_o);
   p_no_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !accept |=> !out_valid_o);

   // R3: encode chaining keeps the produced byte
   p_enc_chain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && mode_i == DIR_ENC) |=> (sop_i || cur_b[0] == out_data_o));

   // R4: decode chaining keeps the recovered plain byte
   p_dec_chain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept && mode_i == DIR_DEC) |=> (sop_i || cur_a[1] == out_data_o));
endmodule

// File: tb/byte_chain_cipher_tb.sv
module byte_chain_cipher_tb;
   localparam int MAXL = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sop = 1'b0;
   logic       mode = 1'b0;
   logic       vin = 1'b0;
   logic [7:0] din = 8'h00;
   logic       rdy, vout;
   logic [7:0] dout;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   byte_chain_cipher u_dut (
      .clk_i(clk), .rst_ni(rst_n), .sop_i(sop), .mode_i(mode),
      .in_valid_i(vin), .in_data_i(din), .in_ready_o(rdy),
      .out_valid_o(vout), .out_data_o(dout)
   );

   function automatic logic [7:0] enc_f(logic [7:0] p, logic [7:0] s1, logic [7:0] s2);
      int t;
      t = ((((p ^ s2 ^ 8'h2B) - 5) & 255) ^ 8'h35);
      t = (t - 8'h39) & 255;
      t = (((t ^ s1 ^ 8'h5A) - 8'hB0) & 255) ^ 8'h38;
      t = (t - 8'h45) & 255;
      return t[7:0];
   endfunction

   function automatic logic [7:0] dec_f(logic [7:0] c, logic [7:0] s1, logic [7:0] s2);
      int t;
      t = (((c + 8'h45) & 255) ^ 8'h38);
      t = (((t + 8'hB0) & 255) ^ 8'h5A ^ s1);
      t = (((t + 8'h39) & 255) ^ 8'h35);
      t = (((t + 5) & 255) ^ 8'h2B ^ s2);
      return t[7:0];
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   logic [7:0] m_p [2];
   logic [7:0] m_c [2];
   int         m_cnt;
   bit         e_vld;
   logic [7:0] e_dat;
   bit         m_rdy;

   assign m_rdy = sop || (m_cnt < MAXL);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 2; i++) begin m_p[i] = 8'h9B; m_c[i] = 8'h54; end
         m_cnt = 0; e_vld = 0; e_dat = 8'h00;
      end else begin
         bit acc;
         logic [7:0] r;
         acc = vin && m_rdy;
         if (sop) begin
            for (int i = 0; i < 2; i++) begin m_p[i] = 8'h9B; m_c[i] = 8'h54; end
            m_cnt = 0;
         end
         e_vld = acc;
         if (acc) begin
            m_cnt++;
            if (!mode) begin
               r = enc_f(din, m_p[0], m_c[0]);
               m_p[0] = din; m_c[0] = r;
            end else begin
               r = dec_f(din, m_p[1], m_c[1]);
               m_p[1] = r; m_c[1] = din;
            end
            e_dat = r;
         end
      end
   end

   logic [7:0] cap [$];

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(rdy == m_rdy, "R6 ready", rdy, m_rdy);
         check(vout == e_vld, "R9 valid", vout, e_vld);
         if (e_vld) check(dout == e_dat, "R3 R4 data", dout, e_dat);
         if (vout) cap.push_back(dout);
      end
   end

   task automatic put(logic [7:0] b, logic m, logic s);
      @(posedge clk); #2;
      vin = 1'b1; din = b; mode = m; sop = s;
   endtask

   task automatic idle(int n);
      @(posedge clk); #2;
      vin = 1'b0; sop = 1'b0;
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic pulse_sop();
      @(posedge clk); #2;
      vin = 1'b0; sop = 1'b1;
   endtask

   task automatic finish_run();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] orig [$];
      logic [7:0] encd [$];
      logic [7:0] solo [$];

      repeat (3) @(posedge clk);
      #2;
      check(vout == 1'b0, "R1 out_valid", vout, 0);
      check(rdy == 1'b1, "R1 ready", rdy, 1);
      rst_n = 1'b1;
      idle(1);

      // R2: known first byte
      cap.delete();
      put(8'h00, 1'b0, 1'b1);
      idle(2);
      check(cap.size() == 1 && cap[0] == 8'hDA, "R2 first byte", cap.size() ? cap[0] : -1, 8'hDA);

      // R4: decode of the same byte
      cap.delete();
      put(8'hDA, 1'b1, 1'b1);
      idle(2);
      check(cap.size() == 1 && cap[0] == 8'h00, "R4 first byte", cap.size() ? cap[0] : -1, 0);

      // R5: sop mid message restores seeds
      cap.delete();
      put(8'h11, 1'b0, 1'b1);
      put(8'h22, 1'b0, 1'b0);
      put(8'h33, 1'b0, 1'b0);
      put(8'h00, 1'b0, 1'b1);
      idle(2);
      check(cap.size() == 4 && cap[3] == 8'hDA, "R5 restart", cap.size() == 4 ? cap[3] : -1, 8'hDA);
      pulse_sop();
      idle(1);
      cap.delete();
      put(8'h00, 1'b0, 1'b0);
      idle(2);
      check(cap.size() == 1 && cap[0] == 8'hDA, "R5 bare sop", cap.size() ? cap[0] : -1, 8'hDA);

      // R8: interleaving does not disturb the other direction
      cap.delete();
      put(8'hA5, 1'b0, 1'b1);
      put(8'h3C, 1'b0, 1'b0);
      idle(2);
      solo = cap;
      cap.delete();
      put(8'hA5, 1'b0, 1'b1);
      put(8'h77, 1'b1, 1'b0);
      put(8'h3C, 1'b0, 1'b0);
      idle(2);
      check(cap.size() == 3 && solo.size() == 2 && cap[2] == solo[1], "R8 interleave",
            cap.size() == 3 ? cap[2] : -1, solo.size() == 2 ? solo[1] : -1);

      // R7 and R6: full-length message, then the limit
      cap.delete();
      for (int i = 0; i < MAXL; i++) begin
         orig.push_back(8'((i * 37 + 5) & 255));
         put(orig[i], 1'b0, i == 0);
         if (i % 9 == 4) idle(1);
      end
      idle(2);
      encd = cap;
      check(encd.size() == MAXL, "R7 enc count", encd.size(), MAXL);
      check(rdy == 1'b0, "R6 full", rdy, 0);
      cap.delete();
      put(8'h55, 1'b0, 1'b0);
      idle(3);
      check(cap.size() == 0, "R6 ignored", cap.size(), 0);

      cap.delete();
      for (int i = 0; i < MAXL; i++) put(encd[i], 1'b1, i == 0);
      idle(2);
      check(cap.size() == MAXL, "R7 dec count", cap.size(), MAXL);
      for (int i = 0; i < MAXL && i < cap.size(); i++)
         check(cap[i] == orig[i], "R7 roundtrip", cap[i], orig[i]);

      // R7: short one-byte message
      cap.delete();
      put(8'hFF, 1'b0, 1'b1);
      idle(2);
      put(cap[0], 1'b1, 1'b1);
      idle(2);
      check(cap.size() == 2 && cap[1] == 8'hFF, "R7 single", cap.size() == 2 ? cap[1] : -1, 8'hFF);

      finish_run();
   end
endmodule